// File: doc/BRIEF.md
# Receive Status and Tally Counters

This block keeps the per-frame receive outcome of an Ethernet MAC and the event counters tied to it. Each time the receive datapath finishes a frame, it pulses a completion strobe with flags for a bad CRC, a non-byte-aligned end, a FIFO overrun, a missing receive buffer and a group address. The block turns these flags into an 8-bit receive status byte. It classifies the frame as intact, CRC-bad, misaligned or missed, and counts misaligned, CRC-bad and missed frames in three saturating 8-bit counters that clear when read.

A six-bit interrupt status register collects six events: receive-side events, transmit done/error pulses, an overwrite warning, and the moment a counter's top bit first sets. A mask register gates the status bits onto one level interrupt line. Software reaches everything through a simple register port. The port has a one-cycle read strobe with combinational read data and a one-cycle write strobe. Status bits are cleared by writing 1 to them.

Top module: `rx_status_tally`

## Requirements
- R1: After reset every readable register (addresses 0 to 5) reads 0 and `irq` is low.
- R2: On `frm_done` the status byte at address 0 is reloaded. Its bits are: 0 intact, 1 CRC error, 2 alignment error, 3 overrun, 4 missed, 5 group address (1 = multicast/broadcast, 0 = physical). These bits hold until the next frame.
- R3: An alignment error (bit 2) is flagged only when `frm_crc_bad` and `frm_misaligned` are both set, and it always sets bit 1 as well. A misaligned frame with a good CRC is error-free.
- R4: Bit 0 is set exactly when bits 1 to 4 are all clear for that frame.
- R5: A frame is missed (bit 4) when `frm_no_buf` is set or `mon_en` is high at completion.
- R6: Status bit 6 equals `mon_en` and bit 7 equals `crs | col`, both as sampled at the previous clock edge.
- R7: The counter at address 3 counts alignment-error frames, address 4 counts CRC errors without alignment error, and address 5 counts missed frames. Each rises by one per qualifying frame.
- R8: A counter stays at 255 once it reaches 255.
- R9: Reading a counter returns its current value and clears it. A counted frame in the same cycle as the read leaves the counter at 1.
- R10: The interrupt status register at address 1 has these bits: 0 intact frame, 1 `tx_done`, 2 receive error (CRC, overrun or missed), 3 `tx_err`, 4 `ovw_warn`, 5 a counter's bit 7 going from 0 to 1. Bits 7 and 6 read 0.
- R11: The mask at address 2 is read/write, 6 bits wide and resets to 0. `irq` is high exactly when some status bit and its mask bit are both 1.
- R12: Writing address 1 clears each status bit whose data bit is 1. A set event in the same cycle keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | Frame completion strobe |
| frm_crc_bad | input | 1 | CRC mismatch at last byte boundary |
| frm_misaligned | input | 1 | Frame did not end on a byte boundary |
| frm_overrun | input | 1 | Receive FIFO overran |
| frm_no_buf | input | 1 | No receive buffer available |
| frm_group | input | 1 | Destination matched a multicast/broadcast address |
| mon_en | input | 1 | Monitor mode (receiver stores nothing) |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision |
| tx_done | input | 1 | Transmit completed pulse |
| tx_err | input | 1 | Transmit error pulse |
| ovw_warn | input | 1 | Buffer overwrite warning pulse |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while the address is presented |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle, and each pair is checked. The first pair is clear-on-read of a counter and a counted frame. The bench presents a CRC-error frame strobe together with a read of the CRC counter. It checks that the read returns the old value and that a second read returns 1. The second pair is a write-1-to-clear of an interrupt status bit and a new event for that bit. The bench pulses `tx_done` in the same cycle as a clear of bit 1, then checks that the bit and `irq` are still set.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
    localparam int REG_W = 8;
    localparam int ISR_W = 6;
    localparam int NUM_CNT = 3;

    localparam logic [2:0] A_RSR  = 3'd0;
    localparam logic [2:0] A_ISR  = 3'd1;
    localparam logic [2:0] A_IMR  = 3'd2;
    localparam logic [2:0] A_CNT0 = 3'd3;

    // interrupt status bit positions
    localparam int IB_RXOK  = 0;
    localparam int IB_TXOK  = 1;
    localparam int IB_RXERR = 2;
    localparam int IB_TXERR = 3;
    localparam int IB_OVW   = 4;
    localparam int IB_CNT   = 5;

    typedef struct packed {
        logic intact;
        logic rx_err;
        logic fae;
        logic crc_only;
        logic missed;
    } rx_evt_t;
endpackage

// File: rtl/rxst_frame.sv
module rxst_frame
    import rxst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_done,
    input  logic             frm_crc_bad,
    input  logic             frm_misaligned,
    input  logic             frm_overrun,
    input  logic             frm_no_buf,
    input  logic             frm_group,
    input  logic             mon_en,
    input  logic             crs,
    input  logic             col,
    output logic [REG_W-1:0] rsr,
    output rx_evt_t          evt
);
    typedef struct packed {
        logic [REG_W-1:0] rsr;
    } st_t;

    st_t st_d, st_q;
    logic crc_e, fae_e, ovr_e, miss_e;

    always_comb begin
        st_d   = st_q;
        crc_e  = frm_done & frm_crc_bad;
        fae_e  = crc_e & frm_misaligned;
        ovr_e  = frm_done & frm_overrun;
        miss_e = frm_done & (frm_no_buf | mon_en);
        if (frm_done) begin
            st_d.rsr[0] = ~(crc_e | ovr_e | miss_e);
            st_d.rsr[1] = crc_e;
            st_d.rsr[2] = fae_e;
            st_d.rsr[3] = ovr_e;
            st_d.rsr[4] = miss_e;
            st_d.rsr[5] = frm_group;
        end
        st_d.rsr[6] = mon_en;
        st_d.rsr[7] = crs | col;

        evt.intact   = frm_done & ~(crc_e | ovr_e | miss_e);
        evt.rx_err   = crc_e | ovr_e | miss_e;
        evt.fae      = fae_e;
        evt.crc_only = crc_e & ~fae_e;
        evt.missed   = miss_e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsr = st_q.rsr;

    // R3
    fae_implies_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsr[2] |-> st_q.rsr[1]);

    // R4
    intact_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsr[0] |-> (st_q.rsr[4:1] == 4'b0));
endmodule

// File: rtl/rxst_tally.sv
module rxst_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             msb_rise
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = inc ? CNT_ONE : '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_d = cnt_q + CNT_ONE;
        msb_rise = cnt_d[CNT_W-1] & ~cnt_q[CNT_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
endmodule

// File: rtl/rxst_irq.sv
module rxst_irq
    import rxst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] set_ev,
    input  logic             isr_wr,
    input  logic             imr_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [ISR_W-1:0] isr,
    output logic [ISR_W-1:0] imr,
    output logic             irq
);
    typedef struct packed {
        logic [ISR_W-1:0] isr;
        logic [ISR_W-1:0] imr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (isr_wr) st_d.isr = st_q.isr & ~wdata[ISR_W-1:0];
        st_d.isr = st_d.isr | set_ev;
        if (imr_wr) st_d.imr = wdata[ISR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr = st_q.isr;
    assign imr = st_q.imr;
    assign irq = |(st_q.isr & st_q.imr);

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> ((st_q.isr & $past(set_ev)) == $past(set_ev)));
endmodule

// File: rtl/rx_status_tally.sv
module rx_status_tally
    import rxst_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_done,
    input  logic             frm_crc_bad,
    input  logic             frm_misaligned,
    input  logic             frm_overrun,
    input  logic             frm_no_buf,
    input  logic             frm_group,
    input  logic             mon_en,
    input  logic             crs,
    input  logic             col,
    input  logic             tx_done,
    input  logic             tx_err,
    input  logic             ovw_warn,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    logic [REG_W-1:0] rsr;
    rx_evt_t          evt;
    logic [NUM_CNT-1:0] cnt_inc, cnt_clr, cnt_rise;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [ISR_W-1:0]   set_ev, isr, imr;

    rxst_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .frm_done(frm_done), .frm_crc_bad(frm_crc_bad),
        .frm_misaligned(frm_misaligned), .frm_overrun(frm_overrun),
        .frm_no_buf(frm_no_buf), .frm_group(frm_group),
        .mon_en(mon_en), .crs(crs), .col(col),
        .rsr(rsr), .evt(evt)
    );

    // counter order follows register address: alignment, CRC, missed
    assign cnt_inc = {evt.missed, evt.crc_only, evt.fae};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign cnt_clr[i] = reg_rd && (reg_addr == A_CNT0 + 3'(i));
        rxst_tally #(.CNT_W(CNT_W)) u_tally (
            .clk(clk), .rst_n(rst_n),
            .inc(cnt_inc[i]), .clr(cnt_clr[i]),
            .cnt(cnt_val[i]), .msb_rise(cnt_rise[i])
        );
    end

    always_comb begin
        set_ev = '0;
        set_ev[IB_RXOK]  = evt.intact;
        set_ev[IB_TXOK]  = tx_done;
        set_ev[IB_RXERR] = evt.rx_err;
        set_ev[IB_TXERR] = tx_err;
        set_ev[IB_OVW]   = ovw_warn;
        set_ev[IB_CNT]   = |cnt_rise;
    end

    rxst_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_ev(set_ev),
        .isr_wr(reg_wr && reg_addr == A_ISR),
        .imr_wr(reg_wr && reg_addr == A_IMR),
        .wdata(reg_wdata),
        .isr(isr), .imr(imr), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RSR:   reg_rdata = rsr;
            A_ISR:   reg_rdata = REG_W'(isr);
            A_IMR:   reg_rdata = REG_W'(imr);
            3'd3:    reg_rdata = REG_W'(cnt_val[0]);
            3'd4:    reg_rdata = REG_W'(cnt_val[1]);
            3'd5:    reg_rdata = REG_W'(cnt_val[2]);
            default: reg_rdata = '0;
        endcase
    end

    // R9
    clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd5 && !evt.missed) |=> (cnt_val[2] == '0));
endmodule

// File: tb/tb_rx_status_tally.sv
`timescale 1ns/100ps
module tb_rx_status_tally;
    logic clk = 0, rst_n = 0;
    logic frm_done = 0, frm_crc_bad = 0, frm_misaligned = 0, frm_overrun = 0;
    logic frm_no_buf = 0, frm_group = 0, mon_en = 0, crs = 0, col = 0;
    logic tx_done = 0, tx_err = 0, ovw_warn = 0;
    logic reg_rd = 0, reg_wr = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic irq;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    rx_status_tally dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_rd = 1; reg_addr = a;
        #1 v = reg_rdata;
        tick();
        reg_rd = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic frame(input logic crc, mis, ovr, nob, grp);
        frm_done = 1; frm_crc_bad = crc; frm_misaligned = mis;
        frm_overrun = ovr; frm_no_buf = nob; frm_group = grp;
        tick();
        frm_done = 0; frm_crc_bad = 0; frm_misaligned = 0;
        frm_overrun = 0; frm_no_buf = 0; frm_group = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg after reset", v, 8'h00);
        end
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_good();
        logic [7:0] v;
        frame(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R2/R4 intact status", v, 8'h01);
        rd(3'd1, v); chk("R10 intact isr", v, 8'h01);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R12 w1c clears", v, 8'h00);
        frame(0, 1, 0, 0, 1);
        rd(3'd0, v); chk("R3 dribble good crc, group", v, 8'h21);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        frame(1, 0, 0, 0, 0);
        rd(3'd0, v); chk("R2 crc status", v, 8'h02);
        rd(3'd1, v); chk("R10 rx error isr", v, 8'h04);
        rd(3'd4, v); chk("R7 crc counter", v, 8'h01);
        rd(3'd3, v); chk("R7 fae counter untouched", v, 8'h00);
        rd(3'd4, v); chk("R9 crc counter cleared", v, 8'h00);
        frame(1, 1, 0, 0, 0);
        rd(3'd0, v); chk("R3 fae status", v, 8'h06);
        rd(3'd3, v); chk("R7 fae counter", v, 8'h01);
        rd(3'd4, v); chk("R7 crc counter not for fae", v, 8'h00);
        frame(0, 0, 1, 0, 0);
        rd(3'd0, v); chk("R4 overrun status", v, 8'h08);
        frame(0, 0, 0, 1, 0);
        rd(3'd0, v); chk("R5 no buffer missed", v, 8'h10);
        rd(3'd5, v); chk("R7 missed counter", v, 8'h01);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_monitor();
        logic [7:0] v;
        mon_en = 1; tick();
        rd(3'd0, v); chk("R6 rx disabled bit", v & 8'h40, 8'h40);
        frame(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R5 monitor missed", v, 8'h50);
        rd(3'd5, v); chk("R7 monitor missed count", v, 8'h01);
        mon_en = 0; tick();
        rd(3'd0, v); chk("R6 rx enabled again", v & 8'h40, 8'h00);
        crs = 1; tick();
        rd(3'd0, v); chk("R6 defer on crs", v & 8'h80, 8'h80);
        crs = 0; col = 1; tick();
        rd(3'd0, v); chk("R6 defer on col", v & 8'h80, 8'h80);
        col = 0; tick();
        rd(3'd0, v); chk("R6 defer clear", v & 8'h80, 8'h00);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        tx_done = 1; tick(); tx_done = 0;
        rd(3'd1, v); chk("R10 tx done isr", v, 8'h02);
        chk("R11 masked no irq", {7'b0, irq}, 8'h00);
        wr(3'd2, 8'h02);
        rd(3'd2, v); chk("R11 mask readback", v, 8'h02);
        chk("R11 irq unmasked", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'h02);
        chk("R12 irq drops after clear", {7'b0, irq}, 8'h00);
        tx_err = 1; ovw_warn = 1; tick(); tx_err = 0; ovw_warn = 0;
        rd(3'd1, v); chk("R10 tx err and ovw", v, 8'h18);
        chk("R11 other bits masked", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'hFF);
        // same-cycle set and clear
        tx_done = 1; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'h02;
        tick();
        tx_done = 0; reg_wr = 0;
        rd(3'd1, v); chk("R12 set wins over clear", v, 8'h02);
        chk("R12 irq kept", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        wr(3'd2, 8'h20);
        for (int i = 0; i < 127; i++) frame(1, 0, 0, 0, 0);
        rd(3'd1, v); chk("R10 no overflow at 127", v & 8'h20, 8'h00);
        frame(1, 0, 0, 0, 0);
        rd(3'd1, v); chk("R10 overflow at msb set", v & 8'h20, 8'h20);
        chk("R11 overflow irq", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'hFF);
        for (int i = 0; i < 130; i++) frame(1, 0, 0, 0, 0);
        rd(3'd4, v); chk("R8 saturates", v, 8'hFF);
        rd(3'd4, v); chk("R9 cleared after read", v, 8'h00);
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] v;
        frame(1, 0, 0, 0, 0);
        frame(1, 0, 0, 0, 0);
        frm_done = 1; frm_crc_bad = 1; reg_rd = 1; reg_addr = 3'd4;
        #1 v = reg_rdata;
        tick();
        frm_done = 0; frm_crc_bad = 0; reg_rd = 0;
        chk("R9 read returns old value", v, 8'h02);
        rd(3'd4, v); chk("R9 race leaves one", v, 8'h01);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_good();
        t_errors();
        t_monitor();
        t_irq();
        t_overflow();
        t_race();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule